// File: doc/BRIEF.md
# DMA Engine Control Register Front End

This block is the register and control front end of a bus-master DMA engine that sits next to a SCSI protocol core. Software programs a transfer through a small word-addressed register port. It writes a start byte count, a start address and an optional list address, then an opcode into the command register. The block turns those writes into a running transfer. It keeps a working byte counter and a working address, asks the bus side for bytes, and collects sticky status flags that drive one interrupt-pending output.

Before a transfer starts, the requested length is limited in two steps. First it is capped at 2^16 bytes, or at 2^24 bytes when the large-transfer enable is high. Then it is shortened so that the transfer ends exactly at a 24-bit address boundary and never crosses one. A separate flush (blast) opcode empties the residual bytes held in the byte-wide data FIFO and reports completion through its own status flag. The block accepts a residual of a single byte. Abort and idle opcodes let software recover from a bus error.

Top module: `dma_ctrl_regs`

## Requirements
- R1: Bits 1:0 of the command register hold the opcode: 0 idle, 1 blast, 2 abort, 3 start. Command bit 7 drives `xfer_dir`. The command register reads back the byte that was last written.
- R2: The registers sit at byte offsets 0x40 (command), 0x44 (start count), 0x48 (start address), 0x4C (working count), 0x50 (working address), 0x54 (status), 0x58 (list address) and 0x5C (working list address). Writes to the working count, working address, working list address and status registers are ignored.
- R3: Writing the start opcode loads three values. The working address and the working list address take the start address and the list address. The working count takes the clamped length.
- R4: The length is capped at 2^16 bytes when `big_xfer_en` is low and at 2^24 bytes when it is high. A request at or below the cap is kept as it is.
- R5: The length is shortened so that the low 24 bits of the start address plus the length never exceed 2^24. The transfer therefore ends exactly at a 24-bit boundary.
- R6: `dma_req` is high while the opcode is start, the working count is nonzero and no error is flagged. Each `byte_ack` accepted with `dma_req` high decrements the count by one and increments `xfer_addr` by one. Done is set one cycle after the count reaches zero.
- R7: The status register bits are: 0 power-down (follows `pwdn`), 1 error, 2 abort, 3 done, 4 SCSI-core interrupt (follows `scsi_irq`), 5 blast complete.
- R8: `irq_pending` is high exactly when any of status bits 1 to 4 is set. Power-down and blast complete alone leave it low.
- R9: A `bus_err` pulse while the opcode is start sets the error flag and stops further byte requests.
- R10: Writing the abort opcode sets the abort flag and stops the transfer. The working count keeps its value.
- R11: While the opcode is blast, `flush_req` is high as long as `fifo_lvl` is nonzero. Blast complete is set once the FIFO is empty, including after a single residual byte.
- R12: The error, abort, done and blast-complete flags are sticky. Only a write of the idle opcode clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| big_xfer_en | input | 1 | Raises the length cap from 2^16 to 2^24 bytes |
| byte_ack | input | 1 | One byte moved (transfer) or popped (blast) |
| bus_err | input | 1 | Bus error indication from the master side |
| fifo_lvl | input | 5 | Bytes currently held in the data FIFO |
| pwdn | input | 1 | Power-down indication |
| scsi_irq | input | 1 | Interrupt from the SCSI protocol core |
| dma_req | output | 1 | Transfer byte request |
| flush_req | output | 1 | FIFO flush request during blast |
| xfer_dir | output | 1 | Transfer direction from command bit 7 |
| xfer_addr | output | 32 | Working transfer address |
| irq_pending | output | 1 | Interrupt pending |

## Verification
A wrong clamp shows up in the working count readback in the very first cycle after the start write, before any byte moves. A counter that steps wrongly shows up as a wrong `xfer_addr` on the next byte, or as `dma_req` staying high past the 24-bit boundary. A lost or wrongly cleared flag shows up in the status word and in `irq_pending` within one cycle of the event or of the idle write. Stale request logic shows up as `dma_req` or `flush_req` staying high after an error, an abort or an empty FIFO.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_BLAST = 2'd1,
      OP_ABORT = 2'd2,
      OP_START = 2'd3
   } dma_op_e;

   localparam int CMD_DIR_BIT = 7;

   localparam int ST_PWDN  = 0;
   localparam int ST_ERR   = 1;
   localparam int ST_ABT   = 2;
   localparam int ST_DONE  = 3;
   localparam int ST_SCSI  = 4;
   localparam int ST_BLAST = 5;
   localparam int ST_W     = 6;

   localparam logic [2:0] REG_CMD   = 3'd0;
   localparam logic [2:0] REG_STC   = 3'd1;
   localparam logic [2:0] REG_SPA   = 3'd2;
   localparam logic [2:0] REG_WBC   = 3'd3;
   localparam logic [2:0] REG_WAC   = 3'd4;
   localparam logic [2:0] REG_STAT  = 3'd5;
   localparam logic [2:0] REG_LIST  = 3'd6;
   localparam logic [2:0] REG_WLIST = 3'd7;
endpackage

// File: rtl/dma_len_clamp.sv
module dma_len_clamp #(
   parameter int DW          = 32,
   parameter int SMALL_W     = 16,
   parameter int LARGE_W     = 24,
   parameter int BOUND_W     = 24,
   parameter bit LARGE_OK    = 1'b1,
   localparam int LW         = BOUND_W + 1
) (
   input  logic [DW-1:0] req_len,
   input  logic [DW-1:0] start_addr,
   input  logic          big_en,
   output logic [LW-1:0] len_o
);
   localparam logic [DW-1:0] CAP_SMALL = DW'(1) << SMALL_W;
   localparam logic [DW-1:0] CAP_LARGE = DW'(1) << LARGE_W;
   localparam logic [LW-1:0] BOUND_TOP = LW'(1) << BOUND_W;

   logic [DW-1:0] cap;
   logic [DW-1:0] capped;
   logic [LW-1:0] room;

   // R4: choose the length cap; the large cap exists only when allowed
   generate
      if (LARGE_OK) begin : g_two_caps
         assign cap = big_en ? CAP_LARGE : CAP_SMALL;
      end else begin : g_one_cap
         logic unused_big;
         assign unused_big = big_en;
         assign cap = CAP_SMALL;
      end
   endgenerate

   always_comb begin
      capped = (req_len > cap) ? cap : req_len;
      // R5: bytes left before the next boundary
      room   = BOUND_TOP - {1'b0, start_addr[BOUND_W-1:0]};
      len_o  = (capped[LW-1:0] > room) ? room : capped[LW-1:0];
   end

   logic [DW-1:0] unused_hi;
   assign unused_hi = start_addr & ~((DW'(1) << BOUND_W) - DW'(1));
endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
   parameter int DW      = 32,
   parameter int BOUND_W = 24,
   localparam int LW     = BOUND_W + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [LW-1:0] len,
   input  logic [DW-1:0] start_addr,
   input  logic [DW-1:0] list_addr,
   input  logic          run,
   input  logic          ack,
   output logic [LW-1:0] cnt,
   output logic [DW-1:0] waddr,
   output logic [DW-1:0] wlist,
   output logic          req,
   output logic          cnt_zero
);
   logic mv;

   assign cnt_zero = (cnt == '0);
   assign req      = run && !cnt_zero;
   assign mv       = ack && req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         waddr <= '0;
         wlist <= '0;
      end else if (load) begin
         cnt   <= len;
         waddr <= start_addr;
         wlist <= list_addr;
      end else if (mv) begin
         cnt   <= cnt - LW'(1);
         waddr <= waddr + DW'(1);
      end
   end

   localparam logic [LW:0] BOUND_END = (LW+1)'(1) << BOUND_W;
   logic [LW:0] end_pos;
   assign end_pos = {2'b00, waddr[BOUND_W-1:0]} + {1'b0, cnt};

   assert_cnt_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> cnt <= $past(cnt));
   assert_load_in_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> end_pos <= BOUND_END);
endmodule

// File: rtl/dma_status.sv
module dma_status
   import dma_regs_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  dma_op_e         op,
   input  logic            wr_idle,
   input  logic            wr_abort,
   input  logic            bus_err,
   input  logic            cnt_zero,
   input  logic            fifo_empty,
   input  logic            pwdn,
   input  logic            scsi_irq,
   output logic [ST_W-1:0] status,
   output logic            irq
);
   logic err_q, abt_q, done_q, blast_q;

   always_ff @(posedge clk) begin
      if (!rst_n || wr_idle) begin
         err_q   <= 1'b0;
         abt_q   <= 1'b0;
         done_q  <= 1'b0;
         blast_q <= 1'b0;
      end else begin
         if (bus_err && op == OP_START)     err_q   <= 1'b1;
         if (wr_abort)                      abt_q   <= 1'b1;
         if (op == OP_START && cnt_zero)    done_q  <= 1'b1;
         if (op == OP_BLAST && fifo_empty)  blast_q <= 1'b1;
      end
   end

   always_comb begin
      status           = '0;
      status[ST_PWDN]  = pwdn;
      status[ST_ERR]   = err_q;
      status[ST_ABT]   = abt_q;
      status[ST_DONE]  = done_q;
      status[ST_SCSI]  = scsi_irq;
      status[ST_BLAST] = blast_q;
   end

   assign irq = err_q | abt_q | done_q | scsi_irq;

   assert_idle_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_idle |=> !err_q && !abt_q && !done_q && !blast_q);
   assert_err_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && op == OP_START && !wr_idle) |=> err_q);
   assert_abort_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_abort && !wr_idle) |=> abt_q);
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
   import dma_regs_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int BASE_IDX = 16,
   parameter int SMALL_W  = 16,
   parameter int LARGE_W  = 24,
   parameter int BOUND_W  = 24,
   parameter int LVL_W    = 5,
   parameter bit LARGE_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              big_xfer_en,
   input  logic              byte_ack,
   input  logic              bus_err,
   input  logic [LVL_W-1:0]  fifo_lvl,
   input  logic              pwdn,
   input  logic              scsi_irq,
   output logic              dma_req,
   output logic              flush_req,
   output logic              xfer_dir,
   output logic [31:0]       xfer_addr,
   output logic              irq_pending
);
   localparam int DW    = 32;
   localparam int LW    = BOUND_W + 1;
   localparam int IDX_W = ADDR_W - 2;

   if (LARGE_W < SMALL_W || LARGE_W > BOUND_W) begin : g_bad_caps
      $error("length caps must satisfy SMALL_W <= LARGE_W <= BOUND_W");
   end
   if (BOUND_W >= DW - 1) begin : g_bad_bound
      $error("BOUND_W must leave headroom inside the data width");
   end
   if (BASE_IDX + 8 > (1 << IDX_W)) begin : g_bad_base
      $error("register window does not fit the address width");
   end

   // address decode
   logic [IDX_W-1:0] idx, idx_off;
   logic             in_rng;
   logic [2:0]       sel;
   assign idx     = reg_addr[ADDR_W-1:2];
   assign idx_off = idx - IDX_W'(BASE_IDX);
   assign in_rng  = (idx >= IDX_W'(BASE_IDX)) && (idx_off < IDX_W'(8)) &&
                    (reg_addr[1:0] == 2'b00);
   assign sel     = idx_off[2:0];

   logic wr_cmd, wr_stc, wr_spa, wr_list;
   assign wr_cmd  = reg_we && in_rng && sel == REG_CMD;
   assign wr_stc  = reg_we && in_rng && sel == REG_STC;
   assign wr_spa  = reg_we && in_rng && sel == REG_SPA;
   assign wr_list = reg_we && in_rng && sel == REG_LIST;

   logic [7:0]    cmd_q;
   logic [DW-1:0] stc_q, spa_q, list_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         stc_q  <= '0;
         spa_q  <= '0;
         list_q <= '0;
      end else begin
         if (wr_cmd)  cmd_q  <= reg_wdata[7:0];
         if (wr_stc)  stc_q  <= reg_wdata;
         if (wr_spa)  spa_q  <= reg_wdata;
         if (wr_list) list_q <= reg_wdata;
      end
   end

   dma_op_e op, new_op;
   assign op     = dma_op_e'(cmd_q[1:0]);
   assign new_op = dma_op_e'(reg_wdata[1:0]);

   logic load, wr_idle, wr_abort;
   assign load     = wr_cmd && new_op == OP_START;
   assign wr_idle  = wr_cmd && new_op == OP_IDLE;
   assign wr_abort = wr_cmd && new_op == OP_ABORT;

   logic [LW-1:0] len;
   dma_len_clamp #(
      .DW(DW), .SMALL_W(SMALL_W), .LARGE_W(LARGE_W),
      .BOUND_W(BOUND_W), .LARGE_OK(LARGE_OK)
   ) u_clamp (
      .req_len(stc_q), .start_addr(spa_q), .big_en(big_xfer_en), .len_o(len)
   );

   logic [ST_W-1:0] status;
   logic            run, cnt_zero;
   logic [LW-1:0]   cnt;
   logic [DW-1:0]   waddr, wlist;

   assign run = (op == OP_START) && !status[ST_ERR];

   dma_xfer_ctr #(.DW(DW), .BOUND_W(BOUND_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(load), .len(len),
      .start_addr(spa_q), .list_addr(list_q), .run(run), .ack(byte_ack),
      .cnt(cnt), .waddr(waddr), .wlist(wlist), .req(dma_req),
      .cnt_zero(cnt_zero)
   );

   dma_status u_stat (
      .clk(clk), .rst_n(rst_n), .op(op), .wr_idle(wr_idle),
      .wr_abort(wr_abort), .bus_err(bus_err), .cnt_zero(cnt_zero),
      .fifo_empty(fifo_lvl == '0), .pwdn(pwdn), .scsi_irq(scsi_irq),
      .status(status), .irq(irq_pending)
   );

   assign flush_req = (op == OP_BLAST) && (fifo_lvl != '0);
   assign xfer_dir  = cmd_q[CMD_DIR_BIT];
   assign xfer_addr = waddr;

   always_comb begin
      reg_rdata = '0;
      if (in_rng) begin
         case (sel)
            REG_CMD:   reg_rdata = {24'b0, cmd_q};
            REG_STC:   reg_rdata = stc_q;
            REG_SPA:   reg_rdata = spa_q;
            REG_WBC:   reg_rdata = {{(DW-LW){1'b0}}, cnt};
            REG_WAC:   reg_rdata = waddr;
            REG_STAT:  reg_rdata = {{(DW-ST_W){1'b0}}, status};
            REG_LIST:  reg_rdata = list_q;
            default:   reg_rdata = wlist;
         endcase
      end
   end

   assert_err_blocks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_ERR] |-> !dma_req);
   assert_flush_only_blast_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> !dma_req);
endmodule

// File: tb/tb_dma_ctrl_regs.sv
`timescale 1ns/100ps
module tb_dma_ctrl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        big_xfer_en = 1'b0;
   logic        byte_ack = 1'b0;
   logic        bus_err = 1'b0;
   logic [4:0]  fifo_lvl = '0;
   logic        pwdn = 1'b0;
   logic        scsi_irq = 1'b0;
   logic        dma_req, flush_req, xfer_dir, irq_pending;
   logic [31:0] xfer_addr;

   always #2.5 clk = ~clk;

   dma_ctrl_regs dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .big_xfer_en(big_xfer_en),
      .byte_ack(byte_ack), .bus_err(bus_err), .fifo_lvl(fifo_lvl),
      .pwdn(pwdn), .scsi_irq(scsi_irq), .dma_req(dma_req),
      .flush_req(flush_req), .xfer_dir(xfer_dir), .xfer_addr(xfer_addr),
      .irq_pending(irq_pending)
   );

   localparam logic [7:0] A_CMD = 8'h40, A_STC = 8'h44, A_SPA = 8'h48,
                          A_WBC = 8'h4C, A_WAC = 8'h50, A_STAT = 8'h54,
                          A_LIST = 8'h58, A_WLIST = 8'h5C;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic acks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); byte_ack = 1'b1;
         @(negedge clk); byte_ack = 1'b0;
         if (fifo_lvl != 0 && flush_req) fifo_lvl = fifo_lvl - 5'd1;
      end
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   typedef struct packed {
      logic        big;
      logic [31:0] stc;
      logic [31:0] spa;
      logic [31:0] exp_len;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'h0000_0100, 32'h0000_1000, 32'h0000_0100},
      '{1'b0, 32'h0002_0000, 32'h0000_0000, 32'h0001_0000},
      '{1'b1, 32'h0002_0000, 32'h0000_0000, 32'h0002_0000},
      '{1'b1, 32'h0200_0000, 32'h0000_0000, 32'h0100_0000},
      '{1'b1, 32'h0000_0100, 32'h00FF_FFF0, 32'h0000_0010},
      '{1'b0, 32'h0000_0008, 32'h12FF_FFFC, 32'h0000_0004},
      '{1'b0, 32'h0000_0000, 32'h0000_0040, 32'h0000_0000},
      '{1'b0, 32'h0001_0000, 32'h0000_0000, 32'h0001_0000},
      '{1'b1, 32'h0100_0000, 32'h0000_0001, 32'h00FF_FFFF}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         nfail++; nchk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(A_CMD, d);  chk("R1 reset cmd", d, 0);
      rd(A_STAT, d); chk("R7 reset status", d, 0);
      chk("R8 reset irq", {31'b0, irq_pending}, 0);
      chk("R6 reset req", {31'b0, dma_req}, 0);
      chk("R11 reset flush", {31'b0, flush_req}, 0);

      // clamp table: R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         big_xfer_en = VEC[v].big;
         wr(A_STC, VEC[v].stc);
         wr(A_SPA, VEC[v].spa);
         wr(A_LIST, 32'hABCD_0000 + v);
         wr(A_CMD, 32'h03);
         rd(A_WBC, d);   chk("R4/R5 clamp length", d, VEC[v].exp_len);
         rd(A_WAC, d);   chk("R3 working address", d, VEC[v].spa);
         rd(A_WLIST, d); chk("R3 working list address", d, 32'hABCD_0000 + v);
         wr(A_CMD, 32'h00);
      end
      big_xfer_en = 1'b0;

      // full transfer with direction bit: R1 R6 R8 R12 R2
      wr(A_STC, 4); wr(A_SPA, 32'h100);
      wr(A_CMD, 32'h83);
      rd(A_CMD, d); chk("R1 cmd readback", d, 32'h83);
      chk("R1 direction", {31'b0, xfer_dir}, 1);
      chk("R6 req while running", {31'b0, dma_req}, 1);
      acks(1);
      chk("R6 addr after one byte", xfer_addr, 32'h101);
      acks(3); settle();
      rd(A_WBC, d);  chk("R6 count zero", d, 0);
      chk("R6 final address", xfer_addr, 32'h104);
      chk("R6 req off at zero", {31'b0, dma_req}, 0);
      rd(A_STAT, d); chk("R6 done flag", d, 32'h08);
      chk("R8 irq on done", {31'b0, irq_pending}, 1);
      repeat (4) @(negedge clk);
      rd(A_STAT, d); chk("R12 done sticky", d, 32'h08);
      wr(A_WBC, 32'h55); wr(A_WAC, 32'h77); wr(A_STAT, 32'h3F);
      rd(A_WBC, d);  chk("R2 working count write ignored", d, 0);
      rd(A_WAC, d);  chk("R2 working addr write ignored", d, 32'h104);
      rd(A_STAT, d); chk("R2 status write ignored", d, 32'h08);
      wr(A_CMD, 32'h00);
      rd(A_STAT, d); chk("R12 idle clears done", d, 0);
      chk("R8 irq cleared", {31'b0, irq_pending}, 0);
      chk("R1 direction cleared", {31'b0, xfer_dir}, 0);

      // transfer that stops at the 24-bit boundary: R5
      wr(A_STC, 8); wr(A_SPA, 32'h12FF_FFFC);
      wr(A_CMD, 32'h03);
      acks(6); settle();
      chk("R5 stops at boundary", xfer_addr, 32'h1300_0000);
      rd(A_STAT, d); chk("R5 done at boundary", d, 32'h08);
      wr(A_CMD, 32'h00);

      // error then abort then idle: R9 R10 R12
      wr(A_STC, 16); wr(A_SPA, 32'h200);
      wr(A_CMD, 32'h03);
      acks(3);
      rd(A_WBC, d); chk("R6 count after three", d, 13);
      @(negedge clk); bus_err = 1'b1;
      @(negedge clk); bus_err = 1'b0;
      rd(A_STAT, d); chk("R9 error flag", d, 32'h02);
      chk("R9 req stopped", {31'b0, dma_req}, 0);
      chk("R8 irq on error", {31'b0, irq_pending}, 1);
      acks(1);
      rd(A_WBC, d); chk("R9 no move after error", d, 13);
      wr(A_CMD, 32'h02);
      rd(A_STAT, d); chk("R10 abort flag with error", d, 32'h06);
      rd(A_WBC, d);  chk("R10 count frozen", d, 13);
      wr(A_CMD, 32'h00);
      rd(A_STAT, d); chk("R12 idle clears error and abort", d, 0);

      // abort during a clean transfer: R10
      wr(A_CMD, 32'h03);
      acks(2);
      wr(A_CMD, 32'h02);
      rd(A_STAT, d); chk("R10 abort flag", d, 32'h04);
      chk("R10 req stopped", {31'b0, dma_req}, 0);
      chk("R8 irq on abort", {31'b0, irq_pending}, 1);
      acks(2);
      rd(A_WBC, d); chk("R10 count unchanged", d, 14);
      wr(A_CMD, 32'h00);

      // blast with a single residual byte: R11 R8
      fifo_lvl = 5'd1;
      wr(A_CMD, 32'h81);
      chk("R11 flush request", {31'b0, flush_req}, 1);
      rd(A_STAT, d); chk("R11 not complete yet", d, 0);
      acks(1); settle();
      chk("R11 flush off when empty", {31'b0, flush_req}, 0);
      rd(A_STAT, d); chk("R11 blast complete one byte", d, 32'h20);
      chk("R8 blast alone no irq", {31'b0, irq_pending}, 0);
      wr(A_CMD, 32'h00);
      rd(A_STAT, d); chk("R12 idle clears blast", d, 0);

      // blast with three bytes and with an empty FIFO: R11
      fifo_lvl = 5'd3;
      wr(A_CMD, 32'h01);
      acks(2);
      rd(A_STAT, d); chk("R11 incomplete with one left", d, 0);
      acks(1); settle();
      rd(A_STAT, d); chk("R11 blast complete three", d, 32'h20);
      wr(A_CMD, 32'h00);
      wr(A_CMD, 32'h01); settle();
      rd(A_STAT, d); chk("R11 blast empty FIFO", d, 32'h20);
      wr(A_CMD, 32'h00);

      // live inputs: R7 R8
      pwdn = 1'b1;
      rd(A_STAT, d); chk("R7 power-down bit", d, 32'h01);
      chk("R8 power-down no irq", {31'b0, irq_pending}, 0);
      scsi_irq = 1'b1;
      rd(A_STAT, d); chk("R7 scsi bit", d, 32'h11);
      chk("R8 irq on scsi", {31'b0, irq_pending}, 1);
      pwdn = 1'b0; scsi_irq = 1'b0;
      rd(A_STAT, d); chk("R7 live bits follow inputs", d, 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule